// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block runs in the system clock domain and drives an external 256K-word by 8-bit asynchronous static RAM. Its outputs are an 18-bit address, active-low chip select, output enable and write strobe, and one 8-bit data bus. The bus is split at the block edge into an output value, a driver enable and an input value, and the pad ring joins them into the bidirectional pins. On the core side, a valid/ready handshake accepts one command at a time. A command is a read or a write with its address and write data. Completion is signalled by a one-cycle pulse, which also carries the read data when the command was a read.

The memory's nanosecond timing rules are expressed as cycle counts in parameters. Each count must be at least the matching minimum time divided by the clock period, rounded up. The parameters are:
- the access wait for reads,
- the write-strobe width,
- the data hold after the strobe rises,
- the read-to-write bus turnaround.

All strobes, the address and the outgoing data come straight from flops, so their edges do not glitch. Writes are timed by the write strobe while output enable stays high. The controller drives the data bus only in the window around the write strobe.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, chip select, output enable and write strobe are high. The data driver is off, `rspDone` is low and `reqReady` is high. A reset that arrives in the middle of a write ends the write at once.
- R2: `reqReady` is high only when the controller is idle. A request held while a command is in progress waits, and it is accepted only on a clock edge where `reqReady` is high.
- R3: A read holds chip select and output enable low, with the write strobe high, for exactly READ_CYC cycles from the edge that accepts it. At the last of those edges the input bus is captured into `rspRdata`. `rspDone` then goes high for exactly one cycle, READ_CYC edges after the accept edge.
- R4: A write first spends one cycle with chip select low and the write strobe high. It then holds the write strobe low for exactly WE_CYC cycles. Output enable stays high for the whole write, and the write strobe is never low while chip select is high.
- R5: During a write, the data driver is on for exactly WE_CYC + HOLD_CYC cycles. It turns on together with the write-strobe fall and stays on through HOLD_CYC cycles after the strobe rises. The driver is never on while output enable is low.
- R6: While chip select stays low, `memAddr` does not change and equals the accepted address. While the driver stays on, `memDqOut` does not change and equals the accepted write data.
- R7: A write whose previous command was a read waits TURN_CYC extra cycles before its setup cycle, with every strobe high. This makes the write-strobe fall 1 + TURN_CYC edges after the accept edge. A write after a write, or the first write after reset, has no wait and the strobe falls 1 edge after accept.
- R8: A write raises `rspDone` for one cycle, 1 + WE_CYC + HOLD_CYC edges after its accept edge, plus TURN_CYC when R7 applies.
- R9: `rspRdata` changes only when a read completes. A write leaves it at the last value read.
- R10: With a memory attached, data written to an address is returned by a later read of that address, including at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Command present |
| reqReady | output | 1 | Controller idle, command will be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (18) | Word address |
| reqWdata | input | DATA_W (8) | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W (8) | Data of the last completed read |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memAddr | output | ADDR_W (18) | Memory address |
| memDqOut | output | DATA_W (8) | Value for the pad driver |
| memDqOe | output | 1 | Pad driver enable, active high |
| memDqIn | input | DATA_W (8) | Value seen on the data pins |

## Verification
The case that is hardest to reach from the ports is a write that directly follows a read. In that case the controller must insert its turnaround, and it must not drive the bus while the memory might still be driving it. The stimulus table therefore alternates reads and writes, so that both the turnaround path and the write-after-write path run several times, each at measured strobe positions. A reset is also applied while the write strobe is low. After it, the next write must start without turnaround, which shows that the history flag was cleared along with the strobes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RACC,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctrlState_e;

  // Strobes from control to datapath; pin levels are for the next cycle.
  typedef struct packed {
    logic load;
    logic capture;
    logic done;
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
  } strobe_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int READ_CYC = 2,
  parameter int WE_CYC   = 1,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_RW  = (READ_CYC > WE_CYC) ? READ_CYC : WE_CYC;
  localparam int MAX_HT  = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_RW > MAX_HT) ? MAX_RW : MAX_HT;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  ctrlState_e state, nextState;
  logic [CNT_W-1:0] cnt, cntNext;
  logic lastRead, lastReadNext;
  logic cntZero;

  assign cntZero  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    nextState    = state;
    cntNext      = cnt;
    lastReadNext = lastRead;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            nextState = ST_RACC;
            cntNext   = CNT_W'(READ_CYC - 1);
          end else if (lastRead) begin
            nextState = ST_TURN;
            cntNext   = CNT_W'(TURN_CYC - 1);
          end else begin
            nextState = ST_WSETUP;
          end
        end
      end
      ST_RACC: begin
        if (cntZero) begin
          nextState    = ST_IDLE;
          lastReadNext = 1'b1;
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_TURN: begin
        if (cntZero) nextState = ST_WSETUP;
        else         cntNext   = cnt - CNT_W'(1);
      end
      ST_WSETUP: begin
        nextState    = ST_WPULSE;
        cntNext      = CNT_W'(WE_CYC - 1);
        lastReadNext = 1'b0;
      end
      ST_WPULSE: begin
        if (cntZero) begin
          nextState = ST_WHOLD;
          cntNext   = CNT_W'(HOLD_CYC - 1);
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      ST_WHOLD: begin
        if (cntZero) nextState = ST_IDLE;
        else         cntNext   = cnt - CNT_W'(1);
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // Strobe levels decoded from the next state so that the datapath
  // flops switch on the same edge as the state register.
  always_comb begin
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.capture = (state == ST_RACC) && (nextState == ST_IDLE);
    strb.done    = ((state == ST_RACC) || (state == ST_WHOLD)) && (nextState == ST_IDLE);
    strb.ceN     = !((nextState == ST_RACC)   || (nextState == ST_WSETUP) ||
                     (nextState == ST_WPULSE) || (nextState == ST_WHOLD));
    strb.oeN     = (nextState != ST_RACC);
    strb.weN     = (nextState != ST_WPULSE);
    strb.drive   = (nextState == ST_WPULSE) || (nextState == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
    end else begin
      state    <= nextState;
      cnt      <= cntNext;
      lastRead <= lastReadNext;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata
);

  // Pin-facing strobes: every one a flop, reset to the inactive level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN  <= 1'b1;
      memOeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      memCeN  <= strb.ceN;
      memOeN  <= strb.oeN;
      memWeN  <= strb.weN;
      memDqOe <= strb.drive;
      rspDone <= strb.done;
    end
  end

  // Address and outgoing data are loaded once per command and then held.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (strb.load) begin
      memAddr  <= reqAddr;
      memDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rspRdata <= '0;
    else if (strb.capture) rspRdata <= memDqIn;
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8,
  parameter int READ_CYC = 2,
  parameter int WE_CYC   = 1,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  sram_ctrl_fsm #(
    .READ_CYC (READ_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strb     (strb)
  );

  sram_ctrl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rspDone  (rspDone),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/sram_port_ctrl_checker.sv
module sram_port_ctrl_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int WE_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  // Length of the current write-strobe low run, checked when it ends.
  logic [15:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= weLowCnt + 16'd1;
    else              weLowCnt <= '0;
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && !memDqOe));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_we_needs_ce_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 16'(WE_CYC)));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN));

  assert_drive_with_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memCeN);

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

  assert_drive_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> ($past(memOeN) && !memWeN));

endmodule

bind sram_port_ctrl sram_port_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WE_CYC (WE_CYC)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memAddr  (memAddr),
  .memDqOut (memDqOut),
  .memDqOe  (memDqOe)
);

// File: tb/tb_sram_port_ctrl.sv
module tb_sram_port_ctrl;

  localparam int READ_CYC = 2;
  localparam int WE_CYC   = 1;
  localparam int HOLD_CYC = 1;
  localparam int TURN_CYC = 1;
  localparam int NVEC     = 10;

  // Vector layout: [34] write, [33:16] address, [15:8] write data, [7:0] expected read data.
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1, 18'h00000, 8'h3C, 8'h00},
    {1'b1, 18'h3FFFF, 8'hC3, 8'h00},
    {1'b0, 18'h00000, 8'h00, 8'h3C},
    {1'b1, 18'h12345, 8'h5A, 8'h00},
    {1'b0, 18'h3FFFF, 8'h00, 8'hC3},
    {1'b0, 18'h12345, 8'h00, 8'h5A},
    {1'b1, 18'h00000, 8'hFF, 8'h00},
    {1'b1, 18'h00001, 8'h01, 8'h00},
    {1'b0, 18'h00000, 8'h00, 8'hFF},
    {1'b0, 18'h00001, 8'h00, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspDone;
  logic [7:0]  rspRdata;
  logic        memCeN, memOeN, memWeN, memDqOe;
  logic [17:0] memAddr;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hA5;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_port_ctrl #(
    .READ_CYC (READ_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TURN_CYC (TURN_CYC)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspDone  (rspDone),
    .rspRdata (rspRdata),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .memDqIn  (memDqIn)
  );

  // Behavioural memory: drives reads half a cycle after the strobes settle,
  // stores on the rising write strobe while selected.
  logic [7:0] memModel [logic [17:0]];
  logic       prevWeN = 1'b1;
  always @(negedge clk) begin
    if (!prevWeN && memWeN && !memCeN && memDqOe) memModel[memAddr] = memDqOut;
    prevWeN = memWeN;
    if (!memCeN && !memOeN && memWeN)
      memDqIn = memModel.exists(memAddr) ? memModel[memAddr] : 8'h00;
    else
      memDqIn = 8'hA5;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0h expected %0h", 1, 0);
    finishRun();
  end

  task automatic doOp(input logic wr, input logic [17:0] a, input logic [7:0] d,
                      output int doneAt, output int weFall, output int weLow,
                      output int driveCnt, output bit badBus, output bit readyBusy,
                      output bit addrMoved);
    int n;
    int guard;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    guard = 0;
    while (!reqReady && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; doneAt = -1; weFall = -1; weLow = 0; driveCnt = 0;
    badBus = 1'b0; readyBusy = 1'b0; addrMoved = 1'b0;
    while (doneAt < 0 && n < 50) begin
      if (rspDone) doneAt = n;
      else if (reqReady) readyBusy = 1'b1;
      if (!memWeN) begin
        if (weFall < 0) weFall = n;
        weLow++;
        if (memCeN || !memOeN) badBus = 1'b1;
      end
      if (memDqOe) begin
        driveCnt++;
        if (!memOeN || memDqOut != d) badBus = 1'b1;
      end
      if (wr && !memOeN) badBus = 1'b1;
      if (!memCeN && memAddr != a) addrMoved = 1'b1;
      if (doneAt < 0) begin @(negedge clk); n++; end
    end
  endtask

  initial begin : stimulus
    int doneAt, weFall, weLow, driveCnt;
    bit badBus, readyBusy, addrMoved;
    bit prevRead;
    logic [7:0] lastRd;

    // R1: reset values
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDqOe && !rspDone && reqReady, "R1 in reset",
          {memCeN, memOeN, memWeN, memDqOe, rspDone, reqReady}, 6'b111001);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDqOe && !rspDone && reqReady, "R1 after reset",
          {memCeN, memOeN, memWeN, memDqOe, rspDone, reqReady}, 6'b111001);

    prevRead = 1'b0;
    lastRd   = 8'h00;
    for (int i = 0; i < NVEC; i++) begin
      logic        vWr;
      logic [17:0] vAddr;
      logic [7:0]  vData, vExp;
      int          turn;
      {vWr, vAddr, vData, vExp} = VEC[i];
      doOp(vWr, vAddr, vData, doneAt, weFall, weLow, driveCnt, badBus, readyBusy, addrMoved);
      check(!readyBusy, "R2 ready low while busy", readyBusy, 0);
      check(!addrMoved, "R6 address held", addrMoved, 0);
      if (vWr) begin
        turn = prevRead ? TURN_CYC : 0;
        check(weFall == 1 + turn, "R7 strobe fall position", weFall, 1 + turn);
        check(weLow == WE_CYC, "R4 strobe width", weLow, WE_CYC);
        check(driveCnt == WE_CYC + HOLD_CYC, "R5 drive window", driveCnt, WE_CYC + HOLD_CYC);
        check(!badBus, "R5 bus discipline", badBus, 0);
        check(doneAt == 1 + WE_CYC + HOLD_CYC + turn, "R8 write done", doneAt,
              1 + WE_CYC + HOLD_CYC + turn);
        check(rspRdata == lastRd, "R9 read data kept", rspRdata, lastRd);
        prevRead = 1'b0;
      end else begin
        check(doneAt == READ_CYC, "R3 read done", doneAt, READ_CYC);
        check(weFall < 0 && driveCnt == 0, "R3 no write strobe", driveCnt, 0);
        check(rspRdata == vExp, "R10 read back", rspRdata, vExp);
        lastRd   = rspRdata;
        prevRead = 1'b1;
      end
      @(negedge clk);
      check(!rspDone, "R3 done one cycle", rspDone, 0);
    end

    // R1: reset applied while the write strobe is low
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00100; reqWdata = 8'h77;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (TURN_CYC + 1) @(negedge clk);
    check(!memWeN, "R4 strobe low before reset", memWeN, 0);
    rstN = 1'b0;
    #1;
    check(memCeN && memOeN && memWeN && !memDqOe, "R1 reset mid write",
          {memCeN, memOeN, memWeN, memDqOe}, 4'b1110);
    @(negedge clk);
    rstN = 1'b1;

    // R7: reset clears the read history, so no turnaround now
    doOp(1'b1, 18'h00200, 8'h99, doneAt, weFall, weLow, driveCnt, badBus, readyBusy, addrMoved);
    check(weFall == 1, "R7 no turnaround after reset", weFall, 1);
    check(doneAt == 1 + WE_CYC + HOLD_CYC, "R8 write done after reset", doneAt,
          1 + WE_CYC + HOLD_CYC);
    doOp(1'b0, 18'h00200, 8'h00, doneAt, weFall, weLow, driveCnt, badBus, readyBusy, addrMoved);
    check(rspRdata == 8'h99, "R10 read after reset", rspRdata, 8'h99);
    doOp(1'b0, 18'h00100, 8'h00, doneAt, weFall, weLow, driveCnt, badBus, readyBusy, addrMoved);
    check(rspRdata == 8'h00, "R1 aborted write not stored", rspRdata, 8'h00);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule